// File: doc/BRIEF.md
# Ternary Search Array with Learn

This block holds a small table of 72-bit ternary entries. Each entry is a data word paired with a mask word. One command enters per clock on an 11-bit command bus, qualified by a valid strobe, with a 72-bit operand word beside it. The two low command bits choose between reading one stored word, writing one stored word, searching the whole table for an operand key, and learning a key into the table. The upper nine bits carry the parameters: the index of the entry and whether the data or the mask word is meant.

A search compares the key against every entry at once and reports whether any entry matched and which matching entry has the smallest index. Bit 0 of every data word is an occupancy marker: 0 means the slot is free and 1 means it is taken. A learn places the key in the free slot with the smallest index and marks it taken. A full flag shows when no free slot remains. The command side carries no ready signal because the block accepts a command on every cycle that the valid strobe is high, back to back, and never stalls. The read and search results come out as valid-qualified strobes with no ready. The consumer must take each result on the cycle it is shown, and results appear in command order.

Top module: `tcam_learn_array`

## Requirements
- R1: While rst_n is low and after it is released, every data word is zero, every mask word is all ones, full is 0, and rd_valid and srch_valid are 0.
- R2: A command is taken only in a cycle with cmd_valid = 1; with cmd_valid = 0 the table, full, rd_valid and srch_valid are unaffected whatever cmd holds.
- R3: cmd[1:0] selects the operation: 00 read, 01 write, 10 search, 11 learn. For read and write, cmd[2] picks the word (0 data, 1 mask) and cmd[10:3] is the entry index.
- R4: A write stores cmd_data into the selected word of the selected entry; a write whose index is not below DEPTH changes nothing.
- R5: A read raises rd_valid for one cycle in the cycle after the command with the selected word on rd_data, or zero when the index is not below DEPTH.
- R6: A search treats cmd_data as the key. An entry matches when key and data agree on every bit where its mask is 1. srch_valid rises two cycles after the command, with srch_hit set when any entry matches and srch_index holding the smallest matching index, or 0 when there is no match.
- R7: A learn writes cmd_data with bit 0 forced to 1 into the data word, and all ones into the mask word, of the smallest-indexed entry whose data bit 0 is 0.
- R8: A learn issued while full is 1 changes no entry.
- R9: full is 1 exactly when data bit 0 is 1 in every entry, and it follows the table from the cycle after the write or learn that changed it.
- R10: Commands may come on consecutive cycles. A search or read sees every write and learn issued on earlier cycles, and read and search results keep their fixed latencies when they are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies cmd and cmd_data for this cycle |
| cmd | input | 11 | [1:0] operation, [2] word select, [10:3] entry index |
| cmd_data | input | 72 | Write data, search key or learn key |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 72 | Word returned by a read |
| srch_valid | output | 1 | Search result strobe |
| srch_hit | output | 1 | At least one entry matched the key |
| srch_index | output | clog2(DEPTH) | Smallest matching entry index |
| full | output | 1 | No entry has data bit 0 equal to 0 |

## Verification
The checker watches the timing on every cycle: it checks the one-cycle read strobe, each step of the two-stage search pipe, and that no result strobe appears without a command behind it. It also checks that a learn adds exactly one occupied slot when a slot is free and leaves occupancy untouched when the table is full, and that full only rises after a write or learn. The values need the bench's scenarios and its reference model. These are which entry a learn lands in, the ternary compare under sparse masks, lowest-index priority among several matches, out-of-range indices, and a write seen by a search issued on the very next cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  localparam int unsigned CMD_W      = 11;
  localparam int unsigned IDX_FLD_W  = 8;

  typedef enum logic [1:0] {
    OP_PIO_RD = 2'b00,
    OP_PIO_WR = 2'b01,
    OP_SEARCH = 2'b10,
    OP_LEARN  = 2'b11
  } tcam_op_e;

  // Packed layout, MSB first: index [10:3], word select [2], op [1:0] (R3)
  typedef struct packed {
    logic [IDX_FLD_W-1:0] index;
    logic                 mask_sel;
    tcam_op_e             op;
  } tcam_cmd_t;

endpackage

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N    = 16,
  parameter int IW   = 4
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // Lowest set bit wins; idx is zero when nothing is requested.
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/tcam_storage.sv
module tcam_storage #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 72,
  parameter int IW     = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          wr_mask_sel,
  input  logic [IW-1:0]                 wr_idx,
  input  logic [WORD_W-1:0]             wr_data,
  input  logic                          lrn_en,
  input  logic [IW-1:0]                 lrn_idx,
  input  logic [WORD_W-1:0]             lrn_key,
  input  logic                          rd_en,
  input  logic                          rd_mask_sel,
  input  logic                          rd_in_range,
  input  logic [IW-1:0]                 rd_idx,
  output logic                          rd_valid,
  output logic [WORD_W-1:0]             rd_data,
  output logic [DEPTH-1:0][WORD_W-1:0]  data_q,
  output logic [DEPTH-1:0][WORD_W-1:0]  mask_q,
  output logic [DEPTH-1:0]              occupied
);

  localparam logic [WORD_W-1:0] OCC_BIT = WORD_W'(1);

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [WORD_W-1:0] d_r;
    logic [WORD_W-1:0] m_r;
    logic              hit_lrn;
    logic              hit_wr;

    assign hit_lrn = lrn_en && (lrn_idx == IW'(e));
    assign hit_wr  = wr_en  && (wr_idx  == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        d_r <= '0;
        m_r <= '1;
      end else if (hit_lrn) begin
        d_r <= lrn_key | OCC_BIT;
        m_r <= '1;
      end else if (hit_wr) begin
        if (wr_mask_sel) m_r <= wr_data;
        else             d_r <= wr_data;
      end
    end

    assign data_q[e]   = d_r;
    assign mask_q[e]   = m_r;
    assign occupied[e] = d_r[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (!rd_in_range)    rd_data <= '0;
        else if (rd_mask_sel) rd_data <= mask_q[rd_idx];
        else                  rd_data <= data_q[rd_idx];
      end
    end
  end

endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 72
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          srch_en,
  input  logic [WORD_W-1:0]             key,
  input  logic [DEPTH-1:0][WORD_W-1:0]  data_q,
  input  logic [DEPTH-1:0][WORD_W-1:0]  mask_q,
  output logic                          s1_valid,
  output logic [DEPTH-1:0]              s1_match
);

  logic [DEPTH-1:0] cmp_vec;

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign cmp_vec[e] = ~|((key ^ data_q[e]) & mask_q[e]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_match <= '0;
    end else begin
      s1_valid <= srch_en;
      if (srch_en) s1_match <= cmp_vec;
    end
  end

endmodule

// File: rtl/tcam_learn_array.sv
module tcam_learn_array
  import tcam_pkg::*;
#(
  parameter  int DEPTH  = 16,
  parameter  int WORD_W = 72,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [10:0]       cmd,
  input  logic [WORD_W-1:0] cmd_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              srch_valid,
  output logic              srch_hit,
  output logic [IDX_W-1:0]  srch_index,
  output logic              full
);

  tcam_cmd_t  c;
  logic       in_range;
  logic       op_rd, op_wr, op_srch, op_lrn;
  logic [IDX_W-1:0] entry_idx;

  logic [DEPTH-1:0][WORD_W-1:0] data_q;
  logic [DEPTH-1:0][WORD_W-1:0] mask_q;
  logic [DEPTH-1:0]             occupied;
  logic                         free_found;
  logic [IDX_W-1:0]             free_idx;

  logic             s1_valid;
  logic [DEPTH-1:0] s1_match;
  logic             enc_found;
  logic [IDX_W-1:0] enc_idx;

  assign c         = tcam_cmd_t'(cmd);
  assign in_range  = (32'(c.index) < DEPTH);
  assign entry_idx = c.index[IDX_W-1:0];
  assign op_rd     = cmd_valid && (c.op == OP_PIO_RD);
  assign op_wr     = cmd_valid && (c.op == OP_PIO_WR) && in_range;
  assign op_srch   = cmd_valid && (c.op == OP_SEARCH);
  assign op_lrn    = cmd_valid && (c.op == OP_LEARN) && free_found;

  tcam_prio_enc #(.N(DEPTH), .IW(IDX_W)) u_free_enc (
    .req   (~occupied),
    .found (free_found),
    .idx   (free_idx)
  );

  assign full = ~free_found;

  tcam_storage #(.DEPTH(DEPTH), .WORD_W(WORD_W), .IW(IDX_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (op_wr),
    .wr_mask_sel (c.mask_sel),
    .wr_idx      (entry_idx),
    .wr_data     (cmd_data),
    .lrn_en      (op_lrn),
    .lrn_idx     (free_idx),
    .lrn_key     (cmd_data),
    .rd_en       (op_rd),
    .rd_mask_sel (c.mask_sel),
    .rd_in_range (in_range),
    .rd_idx      (entry_idx),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .data_q      (data_q),
    .mask_q      (mask_q),
    .occupied    (occupied)
  );

  tcam_match #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .srch_en  (op_srch),
    .key      (cmd_data),
    .data_q   (data_q),
    .mask_q   (mask_q),
    .s1_valid (s1_valid),
    .s1_match (s1_match)
  );

  tcam_prio_enc #(.N(DEPTH), .IW(IDX_W)) u_hit_enc (
    .req   (s1_match),
    .found (enc_found),
    .idx   (enc_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srch_valid <= 1'b0;
      srch_hit   <= 1'b0;
      srch_index <= '0;
    end else begin
      srch_valid <= s1_valid;
      if (s1_valid) begin
        srch_hit   <= enc_found;
        srch_index <= enc_idx;
      end
    end
  end

endmodule

// File: rtl/tcam_learn_array_chk.sv
module tcam_learn_array_chk #(
  parameter int DEPTH = 16,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic             rd_valid,
  input logic             srch_valid,
  input logic             srch_hit,
  input logic [IW-1:0]    srch_index,
  input logic             full,
  input logic             s1_valid,
  input logic [DEPTH-1:0] occupied
);

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b00) |=> rd_valid); // R5

  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_op == 2'b00) |=> !rd_valid); // R2

  AST_SRCH_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |=> s1_valid); // R6

  AST_SRCH_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> srch_valid); // R6

  AST_SRCH_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !srch_valid); // R10

  AST_MISS_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_valid && !srch_hit) |-> (srch_index == '0)); // R6

  AST_LEARN_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11 && !full)
      |=> ($countones(occupied) == $past($countones(occupied)) + 1)); // R7

  AST_LEARN_FULL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11 && full) |=> $stable(occupied)); // R8

  AST_IDLE_KEEPS_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(occupied)); // R2

  AST_FULL_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> ($past(cmd_valid) && $past(cmd_op[0]))); // R9

endmodule

bind tcam_learn_array tcam_learn_array_chk #(.DEPTH(DEPTH), .IW(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd[1:0]),
  .rd_valid   (rd_valid),
  .srch_valid (srch_valid),
  .srch_hit   (srch_hit),
  .srch_index (srch_index),
  .full       (full),
  .s1_valid   (s1_valid),
  .occupied   (occupied)
);

// File: tb/tcam_learn_array_tb.sv
module tcam_learn_array_tb;

  localparam int DEPTH  = 16;
  localparam int WORD_W = 72;
  localparam int IW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [10:0]       cmd = '0;
  logic [WORD_W-1:0] cmd_data = '0;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;
  logic              srch_valid;
  logic              srch_hit;
  logic [IW-1:0]     srch_index;
  logic              full;

  int checks = 0;
  int errors = 0;

  logic [WORD_W-1:0] m_data [DEPTH];
  logic [WORD_W-1:0] m_mask [DEPTH];

  always #10 clk = ~clk;

  tcam_learn_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
    .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .srch_valid(srch_valid), .srch_hit(srch_hit), .srch_index(srch_index),
    .full(full)
  );

  function automatic logic [WORD_W-1:0] rnd72();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[WORD_W-1:0];
  endfunction

  function automatic int model_free();
    for (int i = 0; i < DEPTH; i++) if (!m_data[i][0]) return i;
    return -1;
  endfunction

  function automatic logic model_full();
    return model_free() < 0;
  endfunction

  function automatic int model_search(logic [WORD_W-1:0] key);
    for (int i = 0; i < DEPTH; i++)
      if (((key ^ m_data[i]) & m_mask[i]) == '0) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string req, logic [WORD_W-1:0] act, logic [WORD_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] op, logic sel, logic [7:0] idx, logic [WORD_W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd       = {idx, sel, op};
    cmd_data  = d;
  endtask

  task automatic go_idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // R4: write, model updated only for an in-range index
  task automatic do_write(logic sel, logic [7:0] idx, logic [WORD_W-1:0] d);
    drive(2'b01, sel, idx, d);
    if (int'(idx) < DEPTH) begin
      if (sel) m_mask[idx] = d;
      else     m_data[idx] = d;
    end
    go_idle();
    chk(full == model_full(), "R9 full after write", WORD_W'(full), WORD_W'(model_full()));
  endtask

  // R5: read result one cycle after the command
  task automatic do_read(logic sel, logic [7:0] idx, string req);
    logic [WORD_W-1:0] exp;
    exp = '0;
    if (int'(idx) < DEPTH) exp = sel ? m_mask[idx] : m_data[idx];
    drive(2'b00, sel, idx, rnd72());
    go_idle();
    chk(rd_valid == 1'b1, {req, " rd_valid"}, WORD_W'(rd_valid), WORD_W'(1));
    chk(rd_data == exp, {req, " rd_data"}, rd_data, exp);
  endtask

  // R6: search result two cycles after the command
  task automatic do_search(logic [WORD_W-1:0] key, string req);
    int r;
    r = model_search(key);
    drive(2'b10, 1'b0, 8'd0, key);
    go_idle();
    chk(srch_valid == 1'b0, {req, " no early srch_valid"}, WORD_W'(srch_valid), '0);
    @(negedge clk);
    chk(srch_valid == 1'b1, {req, " srch_valid"}, WORD_W'(srch_valid), WORD_W'(1));
    chk(srch_hit == (r >= 0), {req, " srch_hit"}, WORD_W'(srch_hit), WORD_W'(r >= 0));
    chk(srch_index == IW'((r < 0) ? 0 : r), {req, " srch_index"},
        WORD_W'(srch_index), WORD_W'((r < 0) ? 0 : r));
  endtask

  // R7/R8: learn into lowest free slot, ignored when full
  task automatic do_learn(logic [WORD_W-1:0] key);
    int f;
    f = model_free();
    drive(2'b11, 1'b0, 8'd0, key);
    if (f >= 0) begin
      m_data[f] = key | WORD_W'(1);
      m_mask[f] = '1;
    end
    go_idle();
    chk(full == model_full(), "R9 full after learn", WORD_W'(full), WORD_W'(model_full()));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r;
    void'($urandom(32'd4711));
    for (int i = 0; i < DEPTH; i++) begin
      m_data[i] = '0;
      m_mask[i] = '1;
    end
    repeat (3) @(negedge clk);
    // R1: values during reset
    chk(full == 1'b0 && rd_valid == 1'b0 && srch_valid == 1'b0, "R1 outputs in reset",
        WORD_W'({full, rd_valid, srch_valid}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(full == 1'b0, "R1 full after reset", WORD_W'(full), '0);
    do_read(1'b0, 8'd0, "R1 data word reset");
    do_read(1'b1, 8'd5, "R1 mask word reset");
    do_search('0, "R1 all-zero key hits entry 0");
    do_search(72'h5, "R1 nonzero key misses");

    // R2: commands with cmd_valid low have no effect
    @(negedge clk);
    cmd = {8'd2, 1'b0, 2'b01};
    cmd_data = '1;
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd = {8'd2, 1'b0, 2'b00};
    @(negedge clk);
    chk(rd_valid == 1'b0, "R2 read with valid low", WORD_W'(rd_valid), '0);
    cmd = {8'd0, 1'b0, 2'b11};
    @(negedge clk);
    chk(full == 1'b0, "R2 learn with valid low", WORD_W'(full), '0);
    do_read(1'b0, 8'd2, "R2 entry untouched");
    do_read(1'b0, 8'd0, "R2 learn with valid low left slot free");

    // R3/R4/R5: field positions and out-of-range index
    do_write(1'b1, 8'd3, 72'hFF_0000_0000_0000_FFFF);
    do_write(1'b0, 8'd3, 72'h12_3456_789A_BCDE_F0F0);
    do_read(1'b1, 8'd3, "R3 mask select bit");
    do_read(1'b0, 8'd3, "R3 data select bit");
    do_write(1'b0, 8'd20, 72'hAB);
    do_read(1'b0, 8'd20, "R5 out-of-range read");
    do_read(1'b0, 8'd4, "R4 out-of-range write ignored");

    // R6: ternary compare, masked-off bits ignored, lowest index wins
    do_write(1'b0, 8'd0, 72'h1);
    do_search(72'h12_FFFF_FFFF_FFFF_F0F0, "R6 masked-off bits ignored");
    do_search(72'h13_3456_789A_BCDE_F0F0, "R6 masked-in bit differs");
    do_write(1'b1, 8'd1, 72'hFF_0000_0000_0000_FFFF);
    do_write(1'b0, 8'd1, 72'h12_0000_0000_0000_F0F0);
    do_search(72'h12_3456_789A_BCDE_F0F0, "R6 lowest of two matches");

    // R7/R9/R8: fill the table by learning
    for (int i = 0; i < DEPTH; i++) do_learn(rnd72());
    chk(full == 1'b1, "R9 full after filling", WORD_W'(full), WORD_W'(1));
    do_learn(72'hDEAD_BEEF);
    for (int i = 0; i < DEPTH; i++) do_read(1'b0, 8'(i), "R8 table after full learn");
    do_read(1'b1, 8'd1, "R7 learn sets mask all ones");
    do_search(m_data[9], "R7 learned key found");
    do_write(1'b0, 8'd7, 72'h4);
    chk(full == 1'b0, "R9 full drops when slot freed", WORD_W'(full), '0);
    do_learn(72'hC0FFEE);
    do_read(1'b0, 8'd7, "R7 learn goes to freed slot");

    // R10: write, search and read on consecutive cycles
    drive(2'b01, 1'b0, 8'd4, 72'h77_1111_2222_3333_4445);
    m_data[4] = 72'h77_1111_2222_3333_4445;
    r = model_search(72'h77_1111_2222_3333_4445);
    drive(2'b10, 1'b0, 8'd0, 72'h77_1111_2222_3333_4445);
    drive(2'b00, 1'b0, 8'd4, '0);
    go_idle();
    chk(srch_valid && srch_hit && srch_index == IW'(r), "R10 search sees prior write",
        WORD_W'({srch_valid, srch_hit, srch_index}), WORD_W'({1'b1, 1'b1, IW'(r)}));
    chk(rd_valid && rd_data == m_data[4], "R10 interleaved read", rd_data, m_data[4]);

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      int j;
      logic [WORD_W-1:0] k;
      op = int'($urandom_range(0, 3));
      case (op)
        0: do_read(1'($urandom()), 8'($urandom_range(0, DEPTH + 1)), "R5 random read");
        1: begin
          if ($urandom_range(0, 3) == 0) k = rnd72() & rnd72();
          else k = rnd72();
          do_write(1'($urandom()), 8'($urandom_range(0, DEPTH + 1)), k);
        end
        2: begin
          j = int'($urandom_range(0, DEPTH - 1));
          if ($urandom_range(0, 1) == 1) k = m_data[j] ^ (rnd72() & ~m_mask[j]);
          else k = rnd72();
          do_search(k, "R6 random search");
        end
        default: begin
          if ($urandom_range(0, 2) == 0) do_write(1'b0, 8'($urandom_range(0, DEPTH - 1)), '0);
          do_learn(rnd72());
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule